// File: doc/BRIEF.md
# Receiver Error Logger with Sample Hold

This block sits behind the frame decoder of a digital audio interface receiver. Once per received frame it takes seven error flags together with the decoded 24-bit audio word. A per-bit mask selects which of these errors are reported. A reported error does four things:

- it sets a sticky status bit;
- it produces a single-cycle error pulse;
- it keeps an interrupt request level asserted;
- it applies a programmable policy to the outgoing audio word: repeat the last good word, force it to zero, or leave it as it is.

Software reads the status word over a register bus, and the read clears the log. The two checksum-class errors (subcode checksum and channel-status checksum) are logged like the others, but they never touch the audio word. Frame decoding and clock recovery belong to neighbouring blocks.

Top module: `rx_err_logger`

## Requirements
- R1: Status bit positions are: 0 lock lost, 1 validity flag set, 2 low decode confidence, 3 bi-phase coding violation, 4 parity failure, 5 subcode checksum failure, 6 channel-status checksum failure. After reset the status is 0, `err_pulse` is 0, `irq` is 0, `sample_out` is 0 and `sample_vld` is 0.
- R2: A status bit is set by the first unmasked occurrence of its error in a cycle with `frame_stb` high. It stays set across later frames until a read.
- R3: A cycle with `rd_stb` high clears the status on the following clock edge. An unmasked error presented in that same cycle is still set after the clear.
- R4: An error whose `err_mask` bit is 0 sets no status bit, raises no pulse and no interrupt, and has no effect on the audio word.
- R5: `err_pulse` is high for exactly the one cycle after a strobed frame that carries at least one unmasked error, and is low otherwise.
- R6: `irq` is high exactly while some status bit is set whose mask bit is 1.
- R7: With `hold_sel` = 00, a frame with an unmasked error of class 0 to 4 outputs the last audio word that arrived without such an error (0 if there has been none since reset).
- R8: With `hold_sel` = 01, such a frame outputs zero.
- R9: With `hold_sel` = 10 or 11, such a frame outputs its own input word unchanged.
- R10: Errors of class 5 and 6 never alter the output word, whether masked or not.
- R11: The last-good-word register loads the input word only on strobed frames that have no unmasked error of class 0 to 4.
- R12: `sample_out` and `sample_vld` update on the clock edge that samples `frame_stb`. `sample_vld` is high for that one following cycle, and `sample_out` holds its value between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One cycle per received frame; qualifies flags and sample |
| err_flags | input | 7 | Per-frame error flags, bit positions as in R1 |
| sample_in | input | 24 | Decoded audio word of the frame |
| err_mask | input | 7 | 1 = report the error, 0 = ignore it |
| hold_sel | input | 2 | Errored-word policy: 00 repeat, 01 zero, 10/11 pass |
| rd_stb | input | 1 | Status read strobe; clears the log on the next edge |
| err_status | output | 7 | Sticky error log |
| err_pulse | output | 1 | One-cycle pulse per frame with a reported error |
| irq | output | 1 | Interrupt level |
| sample_out | output | 24 | Audio word after the error policy |
| sample_vld | output | 1 | Marks the cycle a new `sample_out` is presented |

## Verification
The bench builds the block with its default parameters: seven error classes, a 24-bit word, and classes 0 to 4 marked as audio-affecting. Seven flags allow every one of the 128 flag patterns to be swept under full, empty and two alternating masks, for all four policy codes. This covers masked versus unmasked reporting, the checksum exemption, and last-good-word tracking exhaustively. Separate sequences cover accumulation without a read, the read-versus-error collision, and the reset state.

// File: rtl/erl_pkg.sv
package erl_pkg;
  localparam int unsigned ERR_N = 7;

  localparam int unsigned B_LOCK   = 0;
  localparam int unsigned B_VALID  = 1;
  localparam int unsigned B_CONF   = 2;
  localparam int unsigned B_BIPH   = 3;
  localparam int unsigned B_PARITY = 4;
  localparam int unsigned B_SUBQ   = 5;
  localparam int unsigned B_CSTAT  = 6;

  typedef enum logic [1:0] {
    POL_REPEAT = 2'b00,
    POL_ZERO   = 2'b01,
    POL_PASS   = 2'b10,
    POL_PASS_X = 2'b11
  } policy_e;
endpackage

// File: rtl/erl_gate.sv
module erl_gate #(
  parameter int unsigned ERR_N = 7,
  parameter logic [ERR_N-1:0] AUDIO_MASK = 7'h1F
) (
  input  logic             frame_stb,
  input  logic [ERR_N-1:0] err_flags,
  input  logic [ERR_N-1:0] err_mask,
  output logic [ERR_N-1:0] hits,
  output logic             any_hit,
  output logic             aud_hit
);
  logic [ERR_N-1:0] aud_bits;

  genvar gi;
  generate
    for (gi = 0; gi < ERR_N; gi++) begin : g_bit
      assign hits[gi]     = frame_stb & err_flags[gi] & err_mask[gi];
      assign aud_bits[gi] = hits[gi] & AUDIO_MASK[gi];
    end
  endgenerate

  always_comb begin
    any_hit = |hits;
    aud_hit = |aud_bits;
  end
endmodule

// File: rtl/erl_status.sv
module erl_status #(
  parameter int unsigned ERR_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] hits,
  input  logic             any_hit,
  input  logic             rd_stb,
  input  logic [ERR_N-1:0] err_mask,
  output logic [ERR_N-1:0] status_q,
  output logic             pulse_q,
  output logic             irq
);
  logic [ERR_N-1:0] status_d;
  logic             pulse_d;

  genvar gi;
  generate
    for (gi = 0; gi < ERR_N; gi++) begin : g_sticky
      always_comb begin
        status_d[gi] = (status_q[gi] & ~rd_stb) | hits[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[gi] <= 1'b0;
        else        status_q[gi] <= status_d[gi];
      end
    end
  endgenerate

  always_comb begin
    pulse_d = any_hit;
    irq     = |(status_q & err_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (hits == '0)) |=> (status_q == '0));

  a_r5_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (status_q != '0));
endmodule

// File: rtl/erl_sample.sv
module erl_sample #(
  parameter int unsigned SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic          aud_hit,
  input  logic [1:0]    hold_sel,
  input  logic [SW-1:0] sample_in,
  output logic [SW-1:0] sample_out,
  output logic          sample_vld
);
  import erl_pkg::*;

  logic [SW-1:0] prev_q, prev_d, out_d, subst;
  logic          prev_en, out_en;
  policy_e       pol;

  always_comb begin
    pol = policy_e'(hold_sel);
    unique case (pol)
      POL_REPEAT: subst = prev_q;
      POL_ZERO:   subst = '0;
      default:    subst = sample_in;
    endcase
    out_en  = frame_stb;
    out_d   = aud_hit ? subst : sample_in;
    prev_en = frame_stb & ~aud_hit;
    prev_d  = sample_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sample_out <= '0;
    else if (out_en) sample_out <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_vld <= 1'b0;
    else        sample_vld <= frame_stb;
  end

  a_r10_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !aud_hit) |=> (sample_out == $past(sample_in)));

  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && aud_hit && hold_sel == 2'b01) |=> (sample_out == '0));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(sample_out));
endmodule

// File: rtl/rx_err_logger.sv
module rx_err_logger #(
  parameter int unsigned ERR_N = erl_pkg::ERR_N,
  parameter int unsigned SW = 24,
  parameter logic [ERR_N-1:0] AUDIO_MASK = 7'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [ERR_N-1:0] err_flags,
  input  logic [SW-1:0]    sample_in,
  input  logic [ERR_N-1:0] err_mask,
  input  logic [1:0]       hold_sel,
  input  logic             rd_stb,
  output logic [ERR_N-1:0] err_status,
  output logic             err_pulse,
  output logic             irq,
  output logic [SW-1:0]    sample_out,
  output logic             sample_vld
);
  logic [ERR_N-1:0] hits;
  logic             any_hit, aud_hit;

  erl_gate #(.ERR_N(ERR_N), .AUDIO_MASK(AUDIO_MASK)) u_gate (
    .frame_stb(frame_stb), .err_flags(err_flags), .err_mask(err_mask),
    .hits(hits), .any_hit(any_hit), .aud_hit(aud_hit)
  );

  erl_status #(.ERR_N(ERR_N)) u_status (
    .clk(clk), .rst_n(rst_n), .hits(hits), .any_hit(any_hit),
    .rd_stb(rd_stb), .err_mask(err_mask), .status_q(err_status),
    .pulse_q(err_pulse), .irq(irq)
  );

  erl_sample #(.SW(SW)) u_sample (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .aud_hit(aud_hit),
    .hold_sel(hold_sel), .sample_in(sample_in), .sample_out(sample_out),
    .sample_vld(sample_vld)
  );

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && ((err_flags & err_mask) == '0)) |=> !err_pulse);

  a_r5_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> !err_pulse);
endmodule

// File: tb/sim_rx_err_logger.sv
module sim_rx_err_logger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic [6:0]  err_flags = '0;
  logic [23:0] sample_in = '0;
  logic [6:0]  err_mask = '0;
  logic [1:0]  hold_sel = '0;
  logic        rd_stb = 1'b0;
  logic [6:0]  err_status;
  logic        err_pulse, irq, sample_vld;
  logic [23:0] sample_out;

  int total = 0;
  int bad = 0;
  logic [23:0] m_prev = '0;
  logic [23:0] m_out  = '0;

  always #2 clk = ~clk;

  rx_err_logger u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .err_flags(err_flags),
    .sample_in(sample_in), .err_mask(err_mask), .hold_sel(hold_sel),
    .rd_stb(rd_stb), .err_status(err_status), .err_pulse(err_pulse),
    .irq(irq), .sample_out(sample_out), .sample_vld(sample_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model of the word path: classes 0..4 affect audio
  task automatic model_frame(input logic [6:0] f, input logic [6:0] m,
                             input logic [1:0] h, input logic [23:0] s);
    logic aud;
    aud = |(f & m & 7'h1F);
    if (aud) begin
      if (h == 2'b00)      m_out = m_prev;
      else if (h == 2'b01) m_out = '0;
      else                 m_out = s;
    end else begin
      m_out  = s;
      m_prev = s;
    end
  endtask

  // one strobed frame at a negedge; outputs checked one edge later
  task automatic frame(input logic [6:0] f, input logic [23:0] s, input logic rd);
    @(negedge clk);
    frame_stb = 1'b1; err_flags = f; sample_in = s; rd_stb = rd;
    model_frame(f, err_mask, hold_sel, s);
    @(negedge clk);
    frame_stb = 1'b0; err_flags = '0; rd_stb = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [6:0] masks [4];
    logic [23:0] s;
    logic [6:0] hit;
    masks[0] = 7'h7F; masks[1] = 7'h00; masks[2] = 7'h55; masks[3] = 7'h2A;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(err_status), 0);
    chk("R1 pulse", 32'(err_pulse), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 sample", 32'(sample_out), 0);
    chk("R1 vld", 32'(sample_vld), 0);
    rst_n = 1'b1;

    // exhaustive sweep: R1 R4 R5 R6 R7 R8 R9 R10 R11 R12
    for (int h = 0; h < 4; h++) begin
      for (int mi = 0; mi < 4; mi++) begin
        for (int f = 0; f < 128; f++) begin
          hold_sel = 2'(h);
          err_mask = masks[mi];
          s   = 24'(32'h5A0000 ^ (f * 32'h9E37) ^ (h << 20) ^ (mi << 18));
          hit = 7'(f) & masks[mi];
          frame(7'(f), s, 1'b0);
          chk("R12 vld", 32'(sample_vld), 1);
          chk("R7/R8/R9/R10/R11 sample", 32'(sample_out), 32'(m_out));
          chk("R1/R2/R4 status", 32'(err_status), 32'(hit));
          chk("R5 pulse", 32'(err_pulse), 32'(|hit));
          chk("R6 irq", 32'(irq), 32'(|hit));
          do_read();
          chk("R3 cleared", 32'(err_status), 0);
          chk("R6 irq after read", 32'(irq), 0);
          chk("R5 pulse single", 32'(err_pulse), 0);
          chk("R12 sample held", 32'(sample_out), 32'(m_out));
          chk("R12 vld low", 32'(sample_vld), 0);
        end
      end
    end

    // R2 accumulation without read, R4 masked class not logged
    err_mask = 7'h7D; hold_sel = 2'b10;
    frame(7'h01, 24'h111111, 1'b0);
    frame(7'h40, 24'h222222, 1'b0);
    frame(7'h02, 24'h333333, 1'b0);
    frame(7'h00, 24'h444444, 1'b0);
    chk("R2 accumulate", 32'(err_status), 32'h41);
    chk("R6 irq sticky", 32'(irq), 1);
    // R6 mask change gates irq
    err_mask = 7'h00;
    @(negedge clk);
    chk("R6 irq masked", 32'(irq), 0);
    err_mask = 7'h7F;

    // R3 read collides with new error: new bit kept, old cleared
    frame(7'h08, 24'h555555, 1'b1);
    chk("R3 race keep", 32'(err_status), 32'h08);
    chk("R3 race pulse", 32'(err_pulse), 1);
    do_read();
    chk("R3 race cleared", 32'(err_status), 0);

    // R7 R11 repeat uses last good word across several bad frames
    hold_sel = 2'b00;
    frame(7'h00, 24'hABCDEF, 1'b0);
    frame(7'h10, 24'h123456, 1'b0);
    chk("R7 repeat 1", 32'(sample_out), 32'hABCDEF);
    frame(7'h04, 24'h654321, 1'b0);
    chk("R11 repeat 2", 32'(sample_out), 32'hABCDEF);
    frame(7'h60, 24'h0F0F0F, 1'b0);
    chk("R10 crc pass", 32'(sample_out), 32'h0F0F0F);
    frame(7'h01, 24'h777777, 1'b0);
    chk("R11 prev after crc", 32'(sample_out), 32'h0F0F0F);
    do_read();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule